// File: doc/BRIEF.md
# Indirect Flash Read Buffer

This block stages an indirect read from a flash device in a small on-chip byte FIFO and hands the bytes to a bus master. After the start command, a flash-side byte producer fills the FIFO through a valid/ready handshake. The block gives the producer the running flash byte address. A memory-mapped read port drains the FIFO in 1, 2 or 4 byte reads. Reads are only served when their address falls inside a programmable trigger window. A read waits while the bytes it needs have not arrived yet. When fewer bytes remain than the read asks for, the unused upper lanes come back as zero.

While the FIFO is full, the producer is held off. When space frees up, it resumes at the next flash address, so no byte is skipped and none is repeated. The current fill level is an output. A sticky interrupt is set when the fill level rises above a programmable threshold. It is also set when the tail of a transfer is sitting in the FIFO, even if the threshold was never crossed. A threshold of zero disables the interrupt. A read outside the window is either handed to a direct-access path or answered with a bus error. A cancel command empties everything at once.

Top module: `irb_top`

## Requirements
- R1: A read inside the window (addr >= base and addr - base < span) returns the next unread transfer bytes in flash order, little-endian: the oldest byte is in bits 7:0. The `s_size` encoding is 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R2: When fewer bytes remain in the transfer than the read size, the read returns only the remaining bytes, and every higher byte lane of `s_rdata` is zero.
- R3: A read whose bytes are already buffered is acknowledged in the cycle after `s_req` is sampled. Otherwise `s_ack` stays low until the producer has delivered enough bytes.
- R4: `fill_level` equals the number of buffered bytes. An acknowledged read lowers it by the number of bytes returned in the same clock edge.
- R5: `fl_ready` is low while 64 bytes are held. `fl_addr` advances by exactly one per accepted byte, so fetching resumes at the first byte not yet fetched.
- R6: With a nonzero `cfg_wmark`, `irq_wmark` is set after `fill_level` rises above it. With `cfg_wmark` = 0 it is never set.
- R7: With a nonzero `cfg_wmark`, `irq_wmark` is also set once every transfer byte has been fetched and buffered bytes remain, whatever the fill level.
- R8: `irq_wmark` is sticky. A pulse on `irq_clr` clears it, and it is set again only by a new rising of its set condition.
- R9: A read outside the window pulses `s_direct` when `cfg_direct_en` = 1 and `s_err` when it is 0. An in-window read when no transfer bytes remain gets `s_err`. At most one of `s_ack`, `s_err`, `s_direct` is high in any cycle.
- R10: One cycle after `cmd_cancel`, `fill_level` is 0, `fl_req` is 0, and later in-window reads get `s_err`.
- R11: One cycle after `cmd_start`, `fl_addr` equals `cfg_flash_start`, the FIFO is empty, and `fl_req` is high when `cfg_xfer_len` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_win_base | input | AW | Trigger window base address |
| cfg_win_span | input | AW | Trigger window size in bytes |
| cfg_direct_en | input | 1 | Route out-of-window reads to the direct path |
| cfg_xfer_len | input | CW | Transfer length in bytes, loaded on start |
| cfg_flash_start | input | FAW | First flash byte address, loaded on start |
| cfg_wmark | input | log2(DEPTH)+1 | Fill threshold, 0 disables the interrupt |
| cmd_start | input | 1 | Start pulse |
| cmd_cancel | input | 1 | Cancel pulse |
| irq_clr | input | 1 | Clear pulse for the interrupt |
| fl_req | output | 1 | Flash bytes still to fetch |
| fl_addr | output | FAW | Flash address of the next byte |
| fl_valid | input | 1 | Producer byte valid |
| fl_data | input | 8 | Producer byte |
| fl_ready | output | 1 | Buffer accepts a byte |
| s_req | input | 1 | Read request, held until a response |
| s_addr | input | AW | Read address |
| s_size | input | 2 | Read size code |
| s_ack | output | 1 | Read data valid |
| s_err | output | 1 | Error response |
| s_direct | output | 1 | Request handed to the direct path |
| s_rdata | output | 32 | Read data, zero-padded |
| fill_level | output | log2(DEPTH)+1 | Buffered byte count |
| irq_wmark | output | 1 | Sticky watermark interrupt |

## Verification
A wrong read pointer or a wrong lane mask shows up as wrong read data on the very next acknowledged read. The bench predicts every byte from the flash address it came from, so skipped or repeated bytes after a full-buffer stall also show up. A drifting fill counter shows up in `fill_level` at the next sample, and also as a read that waits forever or is answered before its bytes arrived. Bad remaining-count bookkeeping shows up within one read as a missing zero pad or a spurious bus error. A flush that misses a register leaves `fill_level` or `fl_req` nonzero one cycle after cancel.

// File: rtl/irb_pkg.sv
package irb_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } rd_size_e;

    localparam int unsigned LANES = 4;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (rd_size_e'(sz))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/irb_fifo.sv
module irb_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [7:0]                 wdata,
    input  logic [2:0]                 pop_n,
    output logic [LANES*8-1:0]         peek,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned FW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [FW-1:0] cnt;
    } ptr_t;

    ptr_t       ptr_d, ptr_q;
    logic [7:0] mem [DEPTH];
    logic       wr_en;

    assign full  = (ptr_q.cnt == FW'(DEPTH));
    assign wr_en = push && !flush && !full;
    assign count = ptr_q.cnt;

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (wr_en) ptr_d.wr = ptr_q.wr + PW'(1);
            ptr_d.rd  = ptr_q.rd + PW'(pop_n);
            ptr_d.cnt = ptr_q.cnt + FW'(wr_en) - FW'(pop_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[ptr_q.wr] <= wdata;
    end

    // one read lane per byte of the widest access
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign peek[g*8 +: 8] = mem[ptr_q.rd + PW'(g)];
    end
endmodule

// File: rtl/irb_win.sv
module irb_win #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] span,
    output logic          in_win
);
    logic [AW-1:0] offset;
    assign offset = addr - base;
    assign in_win = (addr >= base) && (offset < span);
endmodule

// File: rtl/irb_wmark.sv
module irb_wmark #(
    parameter int unsigned FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] fill,
    input  logic [FW-1:0] wmark,
    input  logic          tail_phase,
    input  logic          clr,
    output logic          irq
);
    typedef struct packed {
        logic cond;
        logic irq;
    } wm_t;

    wm_t  wm_d, wm_q;
    logic cond;

    // R6 threshold crossing, R7 tail of transfer buffered
    assign cond = (wmark != '0) &&
                  ((fill > wmark) || (tail_phase && fill != '0));

    always_comb begin
        wm_d.cond = cond;
        wm_d.irq  = (wm_q.irq && !clr) || (cond && !wm_q.cond);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wm_q <= '0;
        else        wm_q <= wm_d;
    end

    assign irq = wm_q.irq;
endmodule

// File: rtl/irb_top.sv
module irb_top
    import irb_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = 16,
    parameter int unsigned AW    = 32,
    parameter int unsigned FAW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           cfg_win_base,
    input  logic [AW-1:0]           cfg_win_span,
    input  logic                    cfg_direct_en,
    input  logic [CW-1:0]           cfg_xfer_len,
    input  logic [FAW-1:0]          cfg_flash_start,
    input  logic [$clog2(DEPTH):0]  cfg_wmark,
    input  logic                    cmd_start,
    input  logic                    cmd_cancel,
    input  logic                    irq_clr,
    output logic                    fl_req,
    output logic [FAW-1:0]          fl_addr,
    input  logic                    fl_valid,
    input  logic [7:0]              fl_data,
    output logic                    fl_ready,
    input  logic                    s_req,
    input  logic [AW-1:0]           s_addr,
    input  logic [1:0]              s_size,
    output logic                    s_ack,
    output logic                    s_err,
    output logic                    s_direct,
    output logic [31:0]             s_rdata,
    output logic [$clog2(DEPTH):0]  fill_level,
    output logic                    irq_wmark
);
    localparam int unsigned FW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [CW-1:0]  fetch;
        logic [CW-1:0]  drain;
        logic [FAW-1:0] faddr;
        logic           ack;
        logic           err;
        logic           dir;
        logic [31:0]    rdata;
    } st_t;

    st_t              st_d, st_q;
    logic             in_win, full, flush, push, take, enough;
    logic [2:0]       want, nbytes, pop_n;
    logic [LANES*8-1:0] peek, masked;
    logic [FW-1:0]    fill;

    assign flush = cmd_start || cmd_cancel;
    assign fl_req   = (st_q.fetch != '0);
    assign fl_ready = fl_req && !full;
    assign push     = fl_valid && fl_ready;

    irb_win #(.AW(AW)) u_win (
        .addr   (s_addr),
        .base   (cfg_win_base),
        .span   (cfg_win_span),
        .in_win (in_win)
    );

    irb_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .wdata (fl_data),
        .pop_n (pop_n),
        .peek  (peek),
        .count (fill),
        .full  (full)
    );

    irb_wmark #(.FW(FW)) u_wmark (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill       (fill),
        .wmark      (cfg_wmark),
        .tail_phase (st_q.fetch == '0 && st_q.drain != '0),
        .clr        (irq_clr),
        .irq        (irq_wmark)
    );

    assign want   = size_bytes(s_size);
    assign nbytes = (CW'(want) > st_q.drain) ? st_q.drain[2:0] : want;
    assign enough = (fill >= FW'(nbytes));
    assign take   = s_req && !(st_q.ack || st_q.err || st_q.dir);

    // zero every lane past the bytes actually returned (R2)
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign masked[g*8 +: 8] = (3'(g) < nbytes) ? peek[g*8 +: 8] : 8'h00;
    end

    always_comb begin
        st_d       = st_q;
        st_d.ack   = 1'b0;
        st_d.err   = 1'b0;
        st_d.dir   = 1'b0;
        st_d.rdata = '0;
        pop_n      = 3'd0;

        if (push) begin
            st_d.fetch = st_q.fetch - CW'(1);
            st_d.faddr = st_q.faddr + FAW'(1);
        end

        if (take) begin
            if (in_win) begin
                if (st_q.drain == '0) begin
                    st_d.err = 1'b1;
                end else if (enough) begin
                    st_d.ack   = 1'b1;
                    st_d.rdata = masked;
                    pop_n      = nbytes;
                    st_d.drain = st_q.drain - CW'(nbytes);
                end
            end else if (cfg_direct_en) begin
                st_d.dir = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end

        if (cmd_start) begin
            st_d.fetch = cfg_xfer_len;
            st_d.drain = cfg_xfer_len;
            st_d.faddr = cfg_flash_start;
            st_d.ack   = 1'b0;
            st_d.rdata = '0;
        end

        if (cmd_cancel) begin
            st_d.fetch = '0;
            st_d.drain = '0;
            st_d.ack   = 1'b0;
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fl_addr    = st_q.faddr;
    assign s_ack      = st_q.ack;
    assign s_err      = st_q.err;
    assign s_direct   = st_q.dir;
    assign s_rdata    = st_q.rdata;
    assign fill_level = fill;
endmodule

// File: rtl/irb_chk.sv
module irb_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned FAW   = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_start,
    input logic                   cmd_cancel,
    input logic [$clog2(DEPTH):0] cfg_wmark,
    input logic                   fl_req,
    input logic [FAW-1:0]         fl_addr,
    input logic                   fl_valid,
    input logic                   fl_ready,
    input logic                   s_req,
    input logic                   s_ack,
    input logic                   s_err,
    input logic                   s_direct,
    input logic [$clog2(DEPTH):0] fill_level,
    input logic                   irq_wmark
);
    localparam int unsigned FW = $clog2(DEPTH) + 1;

    assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level == FW'(DEPTH) |-> !fl_ready);

    assert_addr_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fl_valid && fl_ready) && !$past(cmd_start))
            |-> fl_addr == $past(fl_addr) + FAW'(1));

    assert_one_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_ack, s_err, s_direct}));

    assert_cancel_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cancel && !cmd_start |=> (fill_level == '0) && !fl_req);

    assert_wm_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_wmark) |-> $past(cfg_wmark) != '0);

    assert_ack_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> $past(s_req));
endmodule

bind irb_top irb_chk #(.DEPTH(DEPTH), .FAW(FAW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_cancel (cmd_cancel),
    .cfg_wmark  (cfg_wmark),
    .fl_req     (fl_req),
    .fl_addr    (fl_addr),
    .fl_valid   (fl_valid),
    .fl_ready   (fl_ready),
    .s_req      (s_req),
    .s_ack      (s_ack),
    .s_err      (s_err),
    .s_direct   (s_direct),
    .fill_level (fill_level),
    .irq_wmark  (irq_wmark)
);

// File: tb/sim_irb_top.sv
module sim_irb_top;
    localparam logic [31:0] WBASE = 32'h4000_0000;
    localparam logic [31:0] WSPAN = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_direct_en = 1'b0;
    logic [15:0] cfg_xfer_len = '0;
    logic [31:0] cfg_flash_start = '0;
    logic [6:0]  cfg_wmark = '0;
    logic        cmd_start = 1'b0, cmd_cancel = 1'b0, irq_clr = 1'b0;
    logic        fl_req, fl_ready, fl_valid = 1'b0;
    logic [31:0] fl_addr;
    logic [7:0]  fl_data = '0;
    logic        s_req = 1'b0;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_size = '0;
    logic        s_ack, s_err, s_direct, irq_wmark;
    logic [31:0] s_rdata;
    logic [6:0]  fill_level;

    int checks = 0, fails = 0;
    bit prod_on = 1'b0;

    always #10 clk = ~clk;

    irb_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_win_base(WBASE), .cfg_win_span(WSPAN), .cfg_direct_en(cfg_direct_en),
        .cfg_xfer_len(cfg_xfer_len), .cfg_flash_start(cfg_flash_start), .cfg_wmark(cfg_wmark),
        .cmd_start(cmd_start), .cmd_cancel(cmd_cancel), .irq_clr(irq_clr),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_valid(fl_valid), .fl_data(fl_data),
        .fl_ready(fl_ready),
        .s_req(s_req), .s_addr(s_addr), .s_size(s_size),
        .s_ack(s_ack), .s_err(s_err), .s_direct(s_direct), .s_rdata(s_rdata),
        .fill_level(fill_level), .irq_wmark(irq_wmark)
    );

    function automatic logic [7:0] pat(input logic [31:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] fa, input int n);
        logic [31:0] w = '0;
        for (int i = 0; i < n; i++) w[i*8 +: 8] = pat(fa + 32'(i));
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // flash-side byte producer: data is a function of the flash address
    initial forever begin
        @(negedge clk);
        fl_valid = prod_on && ($urandom % 4 != 0);
        fl_data  = pat(fl_addr);
    end

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic start_xfer(input int len, input logic [31:0] fa, input logic [6:0] wm);
        cfg_xfer_len = 16'(len); cfg_flash_start = fa; cfg_wmark = wm;
        pulse(cmd_start);
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz, output bit ack,
                      output bit err, output bit dir, output logic [31:0] d, output int cyc);
        @(negedge clk);
        s_req = 1'b1; s_addr = a; s_size = sz; cyc = 0;
        do begin
            @(negedge clk); cyc++;
        end while (!(s_ack || s_err || s_direct) && cyc < 2000);
        ack = s_ack; err = s_err; dir = s_direct; d = s_rdata;
        s_req = 1'b0;
    endtask

    task automatic drain_check(input int len, input logic [31:0] fa, input bit words_only);
        int done = 0;
        while (done < len) begin
            bit a, e, dr; logic [31:0] d; int cyc, want, n; logic [1:0] sz;
            sz = words_only ? 2'd2 : 2'($urandom % 4);
            want = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
            n = (len - done < want) ? len - done : want;
            rd(WBASE + 32'(($urandom % 64) * 4), sz, a, e, dr, d, cyc);
            check(a, "R1 ack for in-window read", 32'(a), 32'd1);
            if (n < want) check(d == exp_word(fa + 32'(done), n), "R2 zero pad", d,
                                exp_word(fa + 32'(done), n));
            else check(d == exp_word(fa + 32'(done), n), "R1 read data", d,
                       exp_word(fa + 32'(done), n));
            done += n;
        end
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk); wd++;
            if (wd > 150000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        bit a, e, dr; logic [31:0] d; int cyc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fill_level == 0 && !fl_req && !s_ack && !irq_wmark, "R4 reset state",
              {fill_level, fl_req, s_ack, irq_wmark}, 32'd0);

        // R11 start, then random mixed-size drain with tail padding
        start_xfer(37, 32'h0000_0100, 7'd0);
        check(fl_addr == 32'h100 && fl_req && fill_level == 0, "R11 start load",
              fl_addr, 32'h100);
        prod_on = 1'b1;
        drain_check(37, 32'h100, 1'b0);
        rd(WBASE + 32'h10, 2'd2, a, e, dr, d, cyc);
        check(e && !a, "R9 in-window read with nothing left", 32'(e), 32'd1);

        // R5 full buffer stall and contiguous resume, R3 immediate ack, R4 release
        start_xfer(100, 32'h0000_2000, 7'd0);
        repeat (300) @(negedge clk);
        check(fill_level == 7'd64 && !fl_ready, "R5 full stall", 32'(fill_level), 32'd64);
        check(fl_addr == 32'h2040, "R5 stalled address", fl_addr, 32'h2040);
        rd(WBASE, 2'd2, a, e, dr, d, cyc);
        check(cyc == 1, "R3 minimum latency", 32'(cyc), 32'd1);
        check(fill_level == 7'd60, "R4 space released", 32'(fill_level), 32'd60);
        check(d == exp_word(32'h2000, 4), "R1 first word", d, exp_word(32'h2000, 4));
        drain_check(96, 32'h2004, 1'b1);

        // R3 wait states while data is missing
        prod_on = 1'b0;
        start_xfer(8, 32'h0000_3000, 7'd0);
        @(negedge clk);
        s_req = 1'b1; s_addr = WBASE + 32'h8; s_size = 2'd2;
        begin
            bit early = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (s_ack || s_err) early = 1'b1;
            end
            check(!early, "R3 wait while empty", 32'(early), 32'd0);
        end
        prod_on = 1'b1;
        cyc = 0;
        while (!s_ack && cyc < 500) begin @(negedge clk); cyc++; end
        check(s_ack && s_rdata == exp_word(32'h3000, 4), "R3 data after wait", s_rdata,
              exp_word(32'h3000, 4));
        s_req = 1'b0;
        drain_check(4, 32'h3004, 1'b1);

        // R9 out-of-window routing
        cfg_direct_en = 1'b1;
        rd(32'h1000_0000, 2'd2, a, e, dr, d, cyc);
        check(dr && !e && !a, "R9 direct path", {29'd0, a, e, dr}, 32'd1);
        cfg_direct_en = 1'b0;
        rd(WBASE + WSPAN, 2'd0, a, e, dr, d, cyc);
        check(e && !dr && !a, "R9 error response", {29'd0, a, e, dr}, 32'd2);

        // R6 threshold crossing, R8 sticky clear
        pulse(irq_clr);
        start_xfer(40, 32'h0000_4000, 7'd10);
        repeat (150) @(negedge clk);
        check(irq_wmark, "R6 watermark raised", 32'(irq_wmark), 32'd1);
        pulse(irq_clr);
        repeat (5) @(negedge clk);
        check(!irq_wmark, "R8 cleared stays clear", 32'(irq_wmark), 32'd0);

        // R10 cancel mid transfer
        start_xfer(50, 32'h0000_5000, 7'd0);
        repeat (20) @(negedge clk);
        cmd_cancel = 1'b1;
        @(negedge clk); cmd_cancel = 1'b0;
        check(fill_level == 0 && !fl_req, "R10 cancel flush", {fill_level, fl_req}, 32'd0);
        rd(WBASE, 2'd2, a, e, dr, d, cyc);
        check(e, "R10 read after cancel", 32'(e), 32'd1);

        // R6 zero watermark disables
        pulse(irq_clr);
        start_xfer(40, 32'h0000_6000, 7'd0);
        repeat (150) @(negedge clk);
        check(!irq_wmark, "R6 zero watermark", 32'(irq_wmark), 32'd0);
        pulse(cmd_cancel);

        // R7 tail of transfer below threshold
        pulse(irq_clr);
        start_xfer(5, 32'h0000_7000, 7'd20);
        repeat (60) @(negedge clk);
        check(fill_level == 7'd5, "R7 tail buffered", 32'(fill_level), 32'd5);
        check(irq_wmark, "R7 tail interrupt", 32'(irq_wmark), 32'd1);
        drain_check(5, 32'h7000, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule